// File: doc/BRIEF.md
# Six-Read Unlock Sequence Detector

This block sits beside a byte-wide static memory interface and watches its access strobes. A nonvolatile store or recall is armed only by a fixed run of six back-to-back reads to special addresses. Five fixed prefix addresses come first. The sixth address picks the command: one value asks for a store, a neighbouring value asks for a recall. Any other access in between throws the matcher back to its start, so ordinary traffic cannot trigger a command by accident.

The host presents a 13-bit address together with a single-cycle read strobe or write strobe. The read strobe marks an access that was opened by chip enable falling. The output-enable state plays no part, so it is not an input at all. When the sixth read matches, the block emits a one-cycle start pulse for the chosen command. The nonvolatile engine then runs that command. While the engine is busy, detection is frozen. When the engine signals completion, the progress counter is cleared. The block also exposes how many steps of the sequence have been matched.

Top module: `unlock_seq_detector`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `seqStep` is 0 and neither `storeStart` nor `recallStart` is high.
- R2: A read whose address equals the key for the current step advances `seqStep` by one, visible one clock after the strobe. The keys are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, for steps 0 to 4 in that order.
- R3: At step 5, a read at 0x0F0F raises `storeStart` for exactly one cycle, one clock after the strobe, and returns `seqStep` to 0. This happens whether or not any write was made earlier.
- R4: At step 5, a read at 0x0F0E raises `recallStart` for exactly one cycle, one clock after the strobe, and returns `seqStep` to 0.
- R5: A read that does not match the key for the current step issues no command. It returns `seqStep` to 0, except when its address is 0x0000, in which case `seqStep` becomes 1.
- R6: A write strobe in any cycle returns `seqStep` to 0 and issues no command. This includes a cycle where a read strobe is high at the same time.
- R7: While `nvBusy` is high and `nvDone` is low, read and write strobes are ignored: `seqStep` holds and no start pulse is issued.
- R8: An `nvDone` pulse clears `seqStep` to 0 one clock later and issues no command. It takes priority over any read or write strobe in the same cycle.
- R9: A cycle with neither strobe high leaves `seqStep` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 13 | Address of the access in this cycle |
| rdStrobe | input | 1 | One-cycle pulse for a chip-enable-controlled read |
| wrStrobe | input | 1 | One-cycle pulse for a write |
| nvBusy | input | 1 | Nonvolatile cycle in progress |
| nvDone | input | 1 | One-cycle pulse when the nonvolatile cycle completes |
| storeStart | output | 1 | One-cycle request to begin a store |
| recallStart | output | 1 | One-cycle request to begin a recall |
| seqStep | output | 3 | Number of sequence steps matched so far (0 to 5) |

## Verification
The completion pulse can land in the same cycle as a read. Two cases matter most: a read that would advance the matcher, and the sixth read that would fire a command. The table provokes both by raising `nvDone` together with a matching read at step 2 and at step 5. It then judges the next cycle: `seqStep` must be 0 and both start pulses must be low. A write that coincides with a matching read, including the final one, is provoked and judged in the same way.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;

  // Strobes from the control decoder to the step datapath; at most one is set.
  typedef struct packed {
    logic advance;     // move to the next step
    logic restart;     // back to step 0
    logic reseed;      // jump to step 1 (mismatch that was itself a first key)
    logic fireStore;   // emit store pulse, back to step 0
    logic fireRecall;  // emit recall pulse, back to step 0
  } seqCmd_t;

endpackage

// File: rtl/seq_unlock_datapath.sv
module seq_unlock_datapath
  import seq_unlock_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PREFIX_LEN = 5,
  parameter int STEP_W = 3,
  parameter logic [ADDR_W-1:0] PREFIX_KEYS [PREFIX_LEN] =
    '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0},
  parameter logic [ADDR_W-1:0] STORE_KEY = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  seqCmd_t           cmd,
  output logic              hitNext,
  output logic              hitFirst,
  output logic              hitStore,
  output logic              hitRecall,
  output logic              atFinal,
  output logic [STEP_W-1:0] stepQ,
  output logic              storeQ,
  output logic              recallQ
);

  logic [PREFIX_LEN-1:0] keyHit;

  // One comparator per prefix key, all evaluated in parallel.
  for (genvar g = 0; g < PREFIX_LEN; g++) begin : gKeyCmp
    assign keyHit[g] = (busAddr == PREFIX_KEYS[g]);
  end

  always_comb begin
    hitNext = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (stepQ == STEP_W'(i)) hitNext = keyHit[i];
    end
  end

  assign hitFirst  = keyHit[0];
  assign hitStore  = (busAddr == STORE_KEY);
  assign hitRecall = (busAddr == RECALL_KEY);
  assign atFinal   = (stepQ == STEP_W'(PREFIX_LEN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ   <= '0;
      storeQ  <= 1'b0;
      recallQ <= 1'b0;
    end else begin
      storeQ  <= cmd.fireStore;
      recallQ <= cmd.fireRecall;
      if (cmd.restart || cmd.fireStore || cmd.fireRecall) stepQ <= '0;
      else if (cmd.reseed)                                stepQ <= STEP_W'(1);
      else if (cmd.advance)                               stepQ <= stepQ + 1'b1;
    end
  end

  // R2: an advance strobe moves the step by exactly one
  a_r2_advance_by_one: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> (stepQ == STEP_W'($past(stepQ) + 1'b1)));

  // R3: a store strobe gives a store pulse and a cleared step
  a_r3_store_fires: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fireStore |=> (storeQ && !recallQ && stepQ == '0));

  // R4: a recall strobe gives a recall pulse and a cleared step
  a_r4_recall_fires: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fireRecall |=> (recallQ && !storeQ && stepQ == '0));

  // R5: a reseed lands on step 1
  a_r5_reseed_one: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reseed |=> (stepQ == STEP_W'(1)));

endmodule

// File: rtl/seq_unlock_control.sv
module seq_unlock_control
  import seq_unlock_pkg::*;
(
  input  logic    rdStrobe,
  input  logic    wrStrobe,
  input  logic    nvBusy,
  input  logic    nvDone,
  input  logic    hitNext,
  input  logic    hitFirst,
  input  logic    hitStore,
  input  logic    hitRecall,
  input  logic    atFinal,
  output seqCmd_t cmd
);

  // Priority: completion, busy freeze, write break, then read matching.
  always_comb begin
    cmd = '0;
    if (nvDone) begin
      cmd.restart = 1'b1;
    end else if (nvBusy) begin
      cmd = '0;
    end else if (wrStrobe) begin
      cmd.restart = 1'b1;
    end else if (rdStrobe) begin
      if (atFinal && hitStore)       cmd.fireStore  = 1'b1;
      else if (atFinal && hitRecall) cmd.fireRecall = 1'b1;
      else if (!atFinal && hitNext)  cmd.advance    = 1'b1;
      else if (hitFirst)             cmd.reseed     = 1'b1;
      else                           cmd.restart    = 1'b1;
    end
  end

endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
  import seq_unlock_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PREFIX_LEN = 5,
  parameter logic [ADDR_W-1:0] PREFIX_KEYS [PREFIX_LEN] =
    '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0},
  parameter logic [ADDR_W-1:0] STORE_KEY = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E,
  localparam int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              nvBusy,
  input  logic              nvDone,
  output logic              storeStart,
  output logic              recallStart,
  output logic [STEP_W-1:0] seqStep
);

  seqCmd_t cmd;
  logic hitNext, hitFirst, hitStore, hitRecall, atFinal;

  seq_unlock_control uCtrl (
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .nvBusy   (nvBusy),
    .nvDone   (nvDone),
    .hitNext  (hitNext),
    .hitFirst (hitFirst),
    .hitStore (hitStore),
    .hitRecall(hitRecall),
    .atFinal  (atFinal),
    .cmd      (cmd)
  );

  seq_unlock_datapath #(
    .ADDR_W     (ADDR_W),
    .PREFIX_LEN (PREFIX_LEN),
    .STEP_W     (STEP_W),
    .PREFIX_KEYS(PREFIX_KEYS),
    .STORE_KEY  (STORE_KEY),
    .RECALL_KEY (RECALL_KEY)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .cmd      (cmd),
    .hitNext  (hitNext),
    .hitFirst (hitFirst),
    .hitStore (hitStore),
    .hitRecall(hitRecall),
    .atFinal  (atFinal),
    .stepQ    (seqStep),
    .storeQ   (storeStart),
    .recallQ  (recallStart)
  );

  // R1: reset leaves the step at zero with no pulse
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (seqStep == '0 && !storeStart && !recallStart));

  // R2: the step never exceeds the final position
  a_r2_step_range: assert property (@(posedge clk) disable iff (!rstN)
    seqStep <= STEP_W'(PREFIX_LEN));

  // R3/R4: the two start pulses never overlap, and each coincides with step 0
  a_r3_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStart && recallStart));
  a_r4_pulse_step_zero: assert property (@(posedge clk) disable iff (!rstN)
    (storeStart || recallStart) |-> (seqStep == '0));

  // R6: a write outside busy/done breaks the sequence
  a_r6_write_breaks: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !nvBusy && !nvDone) |=> (seqStep == '0 && !storeStart && !recallStart));

  // R7: busy freezes the matcher
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (nvBusy && !nvDone) |=> ($stable(seqStep) && !storeStart && !recallStart));

  // R8: completion clears the step
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    nvDone |=> (seqStep == '0 && !storeStart && !recallStart));

  // R9: idle cycles leave the step alone
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && !wrStrobe && !nvDone) |=> $stable(seqStep));

endmodule

// File: tb/tb_unlock_seq_detector.sv
module tb_unlock_seq_detector;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 26;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] busAddr = '0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0, nvBusy = 1'b0, nvDone = 1'b0;
  logic        storeStart, recallStart;
  logic [2:0]  seqStep;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_seq_detector dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .nvBusy(nvBusy), .nvDone(nvDone),
    .storeStart(storeStart), .recallStart(recallStart), .seqStep(seqStep)
  );

  // Vector: {req, rd, wr, busy, done, addr, expStep, expStore, expRecall}
  function automatic logic [VW-1:0] v(input int req, input bit rd, input bit wr,
      input bit busy, input bit done, input logic [12:0] a, input int st,
      input bit es, input bit er);
    return {4'(req), rd, wr, busy, done, a, 3'(st), es, er};
  endfunction

  localparam int NV = 47;
  localparam logic [VW-1:0] VEC [NV] = '{
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),   // R2 prefix
    v(2,1,0,0,0,13'h0AAA,3,0,0), v(2,1,0,0,0,13'h1FFF,4,0,0),
    v(9,0,0,0,0,13'h0F0F,4,0,0),                               // R9 idle holds
    v(2,1,0,0,0,13'h10F0,5,0,0), v(3,1,0,0,0,13'h0F0F,0,1,0),   // R3 store
    v(3,0,0,0,0,13'h0000,0,0,0),                               // R3 one-cycle pulse
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),
    v(2,1,0,0,0,13'h0AAA,3,0,0), v(2,1,0,0,0,13'h1FFF,4,0,0),
    v(2,1,0,0,0,13'h10F0,5,0,0), v(4,1,0,0,0,13'h0F0E,0,0,1),   // R4 recall
    v(4,0,0,0,0,13'h0000,0,0,0),
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),
    v(5,1,0,0,0,13'h1234,0,0,0),                               // R5 stray read
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),
    v(2,1,0,0,0,13'h0AAA,3,0,0), v(5,1,0,0,0,13'h0000,1,0,0),   // R5 reseed
    v(2,1,0,0,0,13'h1555,2,0,0), v(6,0,1,0,0,13'h0AAA,0,0,0),   // R6 write
    v(5,1,0,0,0,13'h0F0F,0,0,0),                               // R5 final key early
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),
    v(7,1,0,1,0,13'h0AAA,2,0,0), v(7,0,1,1,0,13'h0000,2,0,0),   // R7 busy
    v(7,0,0,1,0,13'h0000,2,0,0),
    v(8,1,0,1,1,13'h0AAA,0,0,0),                               // R8 done beats read
    v(2,1,0,0,0,13'h0000,1,0,0), v(5,1,0,0,0,13'h0000,1,0,0),
    v(2,1,0,0,0,13'h1555,2,0,0), v(2,1,0,0,0,13'h0AAA,3,0,0),
    v(2,1,0,0,0,13'h1FFF,4,0,0), v(2,1,0,0,0,13'h10F0,5,0,0),
    v(5,1,0,0,0,13'h0F0D,0,0,0),                               // R5 wrong final
    v(2,1,0,0,0,13'h0000,1,0,0), v(6,1,1,0,0,13'h1555,0,0,0),   // R6 read+write
    v(2,1,0,0,0,13'h0000,1,0,0), v(2,1,0,0,0,13'h1555,2,0,0),
    v(2,1,0,0,0,13'h0AAA,3,0,0), v(2,1,0,0,0,13'h1FFF,4,0,0),
    v(2,1,0,0,0,13'h10F0,5,0,0),
    v(8,1,0,0,1,13'h0F0F,0,0,0),                               // R8 done beats final
    v(9,0,0,0,0,13'h0000,0,0,0)
  };

  task automatic drive(input bit rd, input bit wr, input bit busy, input bit done,
      input logic [12:0] a);
    rdStrobe = rd; wrStrobe = wr; nvBusy = busy; nvDone = done; busAddr = a;
  endtask

  // Apply one cycle at a negedge, sample at the following negedge.
  task automatic stepVec(input int req, input bit rd, input bit wr, input bit busy,
      input bit done, input logic [12:0] a, input int st, input bit es, input bit er);
    drive(rd, wr, busy, done, a);
    @(negedge clk);
    checks++;
    if (seqStep !== 3'(st) || storeStart !== es || recallStart !== er) begin
      errors++;
      $display("FAIL R%0d addr=%h step=%0d store=%b recall=%b expected step=%0d store=%b recall=%b",
               req, a, seqStep, storeStart, recallStart, st, es, er);
    end
    drive(0, 0, 0, 0, '0);
  endtask

  task automatic prefix();
    stepVec(2, 1,0,0,0, 13'h0000, 1,0,0);
    stepVec(2, 1,0,0,0, 13'h1555, 2,0,0);
    stepVec(2, 1,0,0,0, 13'h0AAA, 3,0,0);
    stepVec(2, 1,0,0,0, 13'h1FFF, 4,0,0);
    stepVec(2, 1,0,0,0, 13'h10F0, 5,0,0);
  endtask

  initial begin
    // R1: reset state, in reset and right after release
    repeat (2) @(negedge clk);
    checks++;
    if (seqStep !== 0 || storeStart !== 0 || recallStart !== 0) begin
      errors++;
      $display("FAIL R1 in reset step=%0d store=%b recall=%b expected 0 0 0",
               seqStep, storeStart, recallStart);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (seqStep !== 0 || storeStart !== 0 || recallStart !== 0) begin
      errors++;
      $display("FAIL R1 after release step=%0d store=%b recall=%b expected 0 0 0",
               seqStep, storeStart, recallStart);
    end

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      stepVec(int'(e[25:22]), e[21], e[20], e[19], e[18], e[17:5],
              int'(e[4:2]), e[1], e[0]);
    end

    // R6: write coinciding with the final store key fires nothing
    prefix();
    stepVec(6, 1,1,0,0, 13'h0F0F, 0,0,0);
    // R7: busy during the final read holds at step 5, then store once released
    prefix();
    stepVec(7, 1,0,1,0, 13'h0F0F, 5,0,0);
    stepVec(3, 1,0,0,0, 13'h0F0F, 0,1,0);
    // R3: store after a write, back to back with a recall sequence
    stepVec(6, 0,1,0,0, 13'h0100, 0,0,0);
    prefix();
    stepVec(3, 1,0,0,0, 13'h0F0F, 0,1,0);
    prefix();
    stepVec(4, 1,0,0,0, 13'h0F0E, 0,0,1);
    // R1: reset mid-sequence returns to step 0
    stepVec(2, 1,0,0,0, 13'h0000, 1,0,0);
    stepVec(2, 1,0,0,0, 13'h1555, 2,0,0);
    rstN = 1'b0;
    stepVec(1, 1,0,0,0, 13'h0AAA, 0,0,0);
    rstN = 1'b1;
    stepVec(2, 1,0,0,0, 13'h0000, 1,0,0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule